// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Responder

This block sits on the peripheral side of a processor interrupt scheme. A rising edge on its source input makes an interrupt pending, and while the interrupt is pending the block presents its programmed request level on a three-bit encoded request output. A level of zero means no request. When the processor runs an acknowledge cycle, it shows the level being serviced on the address lines. If that level matches the block's level and the block has a pending interrupt, the block answers. It either drives its vector number with a data acknowledge, or it asks the processor to form a vector on its own (autovector). Until software has written the vector register after reset, the block hands back the fixed uninitialized vector, 15.

A bus-timeout monitor watches every acknowledge cycle. It raises bus error when nothing acknowledges the cycle within 16 clocks. Acknowledges from other devices reach the monitor through an input.

The responder is a three-state machine, and every transition in it is named:
- RS_IDLE moves to RS_RESPOND on "claim" (strobe high, level match, request pending).
- RS_IDLE moves to RS_STANDOFF on "pass" (strobe high, no claim).
- RS_RESPOND moves to RS_IDLE on "release" (strobe low). Release also clears the pending request.
- RS_STANDOFF moves to RS_IDLE on "end" (strobe low).

Top module: `irqr_vector_responder`

## Requirements
- R1: After reset, irq_level_o is 0 and dtack_o, avec_o, berr_o and vec_oe_o are all 0.
- R2: A rising edge on src_evt_i, sampled at a clock edge, makes irq_level_o equal level_cfg_i after that edge, and irq_level_o stays at that value while the request is pending. With level_cfg_i = 0 no request is ever shown.
- R3: If iack_cycle_i is high with iack_level_i equal to level_cfg_i while a request is pending, and autovec_mode_i is 0, then dtack_o and vec_oe_o are 1 from the next edge. They stay 1 until the edge that samples iack_cycle_i low.
- R4: If the vector register has not been written since reset, vec_o returns 8'd15 during a response.
- R5: A cycle with cfg_wr_en_i = 1 stores cfg_wr_data_i. Every later response returns the most recently written value.
- R6: With autovec_mode_i = 1, a claimed cycle asserts avec_o instead of dtack_o, and vec_oe_o stays 0.
- R7: An acknowledge cycle at another level, or one arriving with no request pending, produces no dtack_o, avec_o or vec_oe_o, and it leaves a pending request in place.
- R8: The request drops to 0 at the edge that ends the block's own response. It rises again only on a new rising edge of src_evt_i, not on a source that is held high.
- R9: berr_o becomes 1 after the 16th edge at which iack_cycle_i is high with no acknowledge seen (dtack_o, avec_o or ext_ack_i). It holds until iack_cycle_i is sampled low.
- R10: berr_o is never 1 during a cycle that this block acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| level_cfg_i | input | 3 | Programmed request level (0 disables) |
| autovec_mode_i | input | 1 | 1: answer with autovector request |
| src_evt_i | input | 1 | Interrupt source; rising edge raises a request |
| cfg_wr_en_i | input | 1 | Vector register write strobe |
| cfg_wr_data_i | input | 8 | Vector register write data |
| irq_level_o | output | 3 | Encoded request level, 0 = none |
| iack_cycle_i | input | 1 | Acknowledge cycle in progress |
| iack_level_i | input | 3 | Level shown on the address lines |
| ext_ack_i | input | 1 | Another device acknowledged the cycle |
| vec_o | output | 8 | Returned vector number |
| vec_oe_o | output | 1 | Vector bus drive enable |
| dtack_o | output | 1 | Data acknowledge |
| avec_o | output | 1 | Autovector request |
| berr_o | output | 1 | Bus error from the timeout monitor |

## Verification
The hardest situation to reach from the ports is an unanswered acknowledge cycle that runs right up to the timeout boundary while a request is still pending. To get there, the stimulus raises a request at level 3 and then holds the strobe at level 5 for exactly 15 and then 16 edges. This drives the responder into standoff. The checks confirm that bus error appears only after the 16th edge and that the level-3 request survives the foreign cycle. A further pass at the block's own level, in autovector mode, shows that an acknowledge from this block stops the monitor from ever reaching bus error.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
    typedef enum logic [1:0] {
        RS_IDLE     = 2'd0,
        RS_RESPOND  = 2'd1,
        RS_STANDOFF = 2'd2
    } resp_state_e;
endpackage

// File: rtl/irqr_request.sv
module irqr_request #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_evt_i,
    input  logic [LVL_W-1:0] level_cfg_i,
    input  logic             ack_done_i,
    output logic             pending_o,
    output logic [LVL_W-1:0] irq_level_o
);
    logic src_q;
    logic rise;

    assign rise = src_evt_i && !src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q     <= 1'b0;
            pending_o <= 1'b0;
        end else begin
            src_q <= src_evt_i;
            if (rise && (level_cfg_i != '0))
                pending_o <= 1'b1;
            else if (ack_done_i)
                pending_o <= 1'b0;
        end
    end

    assign irq_level_o = pending_o ? level_cfg_i : '0;

    // request only drops through a completed own acknowledge
    assert_req_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending_o) |-> $past(ack_done_i));
endmodule

// File: rtl/irqr_vector_store.sv
module irqr_vector_store #(
    parameter int VEC_W = 8,
    parameter int UNINIT_VEC = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [VEC_W-1:0] wr_data_i,
    output logic [VEC_W-1:0] vec_o
);
    localparam logic [VEC_W-1:0] UNINIT = VEC_W'(UNINIT_VEC);

    logic [VEC_W-1:0] vec_q;
    logic             written_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q     <= '0;
            written_q <= 1'b0;
        end else if (wr_en_i) begin
            vec_q     <= wr_data_i;
            written_q <= 1'b1;
        end
    end

    assign vec_o = written_q ? vec_q : UNINIT;

    // once written, the flag never returns to the uninitialized state
    assert_written_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        written_q |=> written_q);
endmodule

// File: rtl/irqr_responder_fsm.sv
module irqr_responder_fsm
    import irqr_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iack_cycle_i,
    input  logic [LVL_W-1:0] iack_level_i,
    input  logic [LVL_W-1:0] level_cfg_i,
    input  logic             pending_i,
    input  logic             autovec_mode_i,
    output logic             dtack_o,
    output logic             avec_o,
    output logic             vec_oe_o,
    output logic             ack_done_o
);
    resp_state_e state_q, state_d;
    logic        claim;

    assign claim = iack_cycle_i && pending_i && (iack_level_i == level_cfg_i)
                   && (level_cfg_i != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: begin
                if (claim)             state_d = RS_RESPOND;
                else if (iack_cycle_i) state_d = RS_STANDOFF;
            end
            RS_RESPOND:  if (!iack_cycle_i) state_d = RS_IDLE;
            RS_STANDOFF: if (!iack_cycle_i) state_d = RS_IDLE;
            default:     state_d = RS_IDLE;
        endcase
    end

    always_comb begin
        dtack_o    = 1'b0;
        avec_o     = 1'b0;
        vec_oe_o   = 1'b0;
        ack_done_o = 1'b0;
        unique case (state_q)
            RS_RESPOND: begin
                dtack_o    = !autovec_mode_i;
                vec_oe_o   = !autovec_mode_i;
                avec_o     = autovec_mode_i;
                ack_done_o = !iack_cycle_i;
            end
            default: ;
        endcase
    end

    assert_dtack_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_o) |-> $past(iack_cycle_i && iack_level_i == level_cfg_i));
    assert_ack_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(dtack_o && avec_o));
endmodule

// File: rtl/irqr_bus_timeout.sv
module irqr_bus_timeout #(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic iack_cycle_i,
    input  logic any_ack_i,
    output logic berr_o
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!iack_cycle_i)
            cnt_q <= '0;
        else if (!any_ack_i && cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign berr_o = (cnt_q == LIMIT);

    assert_berr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_o && iack_cycle_i) |=> berr_o);
    assert_berr_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(berr_o) |-> $past(iack_cycle_i));
endmodule

// File: rtl/irqr_vector_responder.sv
module irqr_vector_responder #(
    parameter int LVL_W       = 3,
    parameter int VEC_W       = 8,
    parameter int UNINIT_VEC  = 15,
    parameter int TIMEOUT_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_cfg_i,
    input  logic             autovec_mode_i,
    input  logic             src_evt_i,
    input  logic             cfg_wr_en_i,
    input  logic [VEC_W-1:0] cfg_wr_data_i,
    output logic [LVL_W-1:0] irq_level_o,
    input  logic             iack_cycle_i,
    input  logic [LVL_W-1:0] iack_level_i,
    input  logic             ext_ack_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_oe_o,
    output logic             dtack_o,
    output logic             avec_o,
    output logic             berr_o
);
    logic pending;
    logic ack_done;

    irqr_request #(.LVL_W(LVL_W)) u_req (
        .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt_i),
        .level_cfg_i(level_cfg_i), .ack_done_i(ack_done),
        .pending_o(pending), .irq_level_o(irq_level_o)
    );

    irqr_vector_store #(.VEC_W(VEC_W), .UNINIT_VEC(UNINIT_VEC)) u_vec (
        .clk(clk), .rst_n(rst_n), .wr_en_i(cfg_wr_en_i),
        .wr_data_i(cfg_wr_data_i), .vec_o(vec_o)
    );

    irqr_responder_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .iack_cycle_i(iack_cycle_i),
        .iack_level_i(iack_level_i), .level_cfg_i(level_cfg_i),
        .pending_i(pending), .autovec_mode_i(autovec_mode_i),
        .dtack_o(dtack_o), .avec_o(avec_o), .vec_oe_o(vec_oe_o),
        .ack_done_o(ack_done)
    );

    irqr_bus_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .iack_cycle_i(iack_cycle_i),
        .any_ack_i(dtack_o || avec_o || ext_ack_i), .berr_o(berr_o)
    );

    assert_no_berr_with_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(berr_o && (dtack_o || avec_o)));
endmodule

// File: tb/irqr_vector_responder_tb.sv
module irqr_vector_responder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] level_cfg = 3'd3;
    logic       autovec = 1'b0;
    logic       src = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] irq_level;
    logic       iack = 1'b0;
    logic [2:0] iack_lvl = 3'd0;
    logic       ext_ack = 1'b0;
    logic [7:0] vec;
    logic       vec_oe, dtack, avec, berr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irqr_vector_responder dut_i (
        .clk(clk), .rst_n(rst_n), .level_cfg_i(level_cfg), .autovec_mode_i(autovec),
        .src_evt_i(src), .cfg_wr_en_i(wr_en), .cfg_wr_data_i(wr_data),
        .irq_level_o(irq_level), .iack_cycle_i(iack), .iack_level_i(iack_lvl),
        .ext_ack_i(ext_ack), .vec_o(vec), .vec_oe_o(vec_oe), .dtack_o(dtack),
        .avec_o(avec), .berr_o(berr)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic raise_src();
        src = 1'b1;
        step();
        src = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "irq_level", irq_level, 0);
        chk("R1", "dtack", dtack, 0);
        chk("R1", "avec", avec, 0);
        chk("R1", "berr", berr, 0);
        chk("R1", "vec_oe", vec_oe, 0);
    endtask

    task automatic t_uninit();
        src = 1'b1;
        step();
        chk("R2", "level after edge", irq_level, 3);
        iack_lvl = 3'd3; iack = 1'b1;
        step();
        chk("R3", "dtack", dtack, 1);
        chk("R3", "vec_oe", vec_oe, 1);
        chk("R4", "uninit vector", vec, 15);
        step();
        chk("R3", "dtack held", dtack, 1);
        iack = 1'b0;
        step();
        chk("R3", "dtack released", dtack, 0);
        chk("R8", "request dropped", irq_level, 0);
        step(); step();
        chk("R8", "held source no reassert", irq_level, 0);
        src = 1'b0;
        step();
    endtask

    task automatic respond_and_check(input int expv);
        raise_src();
        iack_lvl = 3'd3; iack = 1'b1;
        step();
        chk("R5", "written vector", vec, expv);
        iack = 1'b0;
        step();
    endtask

    task automatic t_write();
        wr_en = 1'b1; wr_data = 8'h42;
        step();
        wr_en = 1'b0;
        respond_and_check(8'h42);
        wr_en = 1'b1; wr_data = 8'h99;
        step();
        wr_en = 1'b0;
        respond_and_check(8'h99);
    endtask

    task automatic t_mismatch_timeout();
        raise_src();
        chk("R8", "new edge reasserts", irq_level, 3);
        iack_lvl = 3'd5; iack = 1'b1;
        for (int i = 0; i < 15; i++) step();
        chk("R7", "no dtack other level", dtack, 0);
        chk("R7", "no vec_oe other level", vec_oe, 0);
        chk("R9", "berr before limit", berr, 0);
        step();
        chk("R9", "berr at limit", berr, 1);
        step();
        chk("R9", "berr held", berr, 1);
        iack = 1'b0;
        step();
        chk("R9", "berr cleared", berr, 0);
        chk("R7", "request kept", irq_level, 3);
    endtask

    task automatic t_autovec();
        autovec = 1'b1;
        iack_lvl = 3'd3; iack = 1'b1;
        step();
        chk("R6", "avec", avec, 1);
        chk("R6", "no dtack", dtack, 0);
        chk("R6", "no vec_oe", vec_oe, 0);
        for (int i = 0; i < 20; i++) step();
        chk("R10", "no berr when acked", berr, 0);
        iack = 1'b0;
        step();
        chk("R8", "request dropped after avec", irq_level, 0);
        autovec = 1'b0;
    endtask

    task automatic t_ext_ack_not_pending();
        iack_lvl = 3'd3; iack = 1'b1; ext_ack = 1'b1;
        for (int i = 0; i < 20; i++) step();
        chk("R7", "no dtack when not pending", dtack, 0);
        chk("R9", "ext ack stops timeout", berr, 0);
        iack = 1'b0; ext_ack = 1'b0;
        step();
    endtask

    task automatic t_level0();
        level_cfg = 3'd0;
        raise_src();
        chk("R2", "level 0 no request", irq_level, 0);
        step();
        level_cfg = 3'd3;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(); step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_uninit();
        t_write();
        t_mismatch_timeout();
        t_autovec();
        t_ext_ack_not_pending();
        t_level0();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule